// File: doc/BRIEF.md
# Sixteen-Level Prioritized Event Controller

This block decides which of sixteen event levels a processor core should service next. Every level has a 32-bit handler address held in a small vector table, and an enable bit in a mask register. Requests come in two ways: a hardware request bit for each level, and a software raise command that names a level by index. Each request is caught in a pending latch. The latch holds the request until the level is dispatched.

On every cycle the controller looks at the pending levels that the mask enables and picks the lowest-numbered one. It dispatches that level only if it outranks every level already in service. A dispatch is a one-cycle pulse that carries the level number and its handler address. The level then counts as active until the core sends a return strobe. This lets a more urgent level nest on top of a less urgent one.

A global-disable command saves the current mask and leaves only the five fixed levels (0 to 4) enabled. Requests keep latching while it is in force. A global-enable command loads a mask that software supplies. Anything still pending and now enabled is then taken in priority order.

Top module: `event_ctrl`

## Requirements
- R1: After reset, `pending_o` and `active_o` are zero, `irq_valid_o` is low, `saved_mask_o` is zero and `mask_o` is 0x001F, so only levels 0 to 4 are enabled.
- R2: A vector write stores `vec_data_i` in the entry selected by `vec_idx_i`. Every dispatch of level L presents entry L on `irq_vector_o`.
- R3: A high bit L of `hw_req_i`, or `raise_i` with `raise_lvl_i` = L, sets pending bit L at the next clock edge. That bit stays set until level L is dispatched.
- R4: A mask write loads `mask_data_i`, where bit L = 1 enables level L. Bits 0 to 4 always read as one. A pending level whose mask bit is clear is not dispatched and stays pending. It is dispatched once its mask bit is set.
- R5: A lower level number means higher priority. The candidate is the lowest-numbered pending level that the mask enables. It is dispatched only when no active level is numbered equal to or lower than it. This lets a higher-priority level preempt a lower one that is already active.
- R6: A dispatch drives `irq_valid_o` high for exactly one cycle, together with `irq_level_o`. The pulse appears one clock after the request was latched. In the same edge the level's pending bit clears and its active bit sets. At most one level is dispatched per cycle.
- R7: `ret_i` clears the lowest-numbered active bit. When no level is active, `ret_i` has no effect.
- R8: `cli_i` copies the current mask to `saved_mask_o` and sets the mask to 0x001F. While this holds, requests for levels 5 to 15 still latch but are not dispatched. Levels 0 to 4 are still dispatched.
- R9: `sti_i` loads `sti_mask_i` with bits 0 to 4 forced to one. Levels that are pending and now enabled are then dispatched one after another in priority order, each after the return of the previous one.
- R10: When several mask commands arrive in the same cycle, `cli_i` wins over `sti_i`, and `sti_i` wins over a mask write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| hw_req_i | input | 16 | Hardware request, one bit per level |
| raise_i | input | 1 | Software raise command |
| raise_lvl_i | input | 4 | Level set pending by the raise command |
| vec_we_i | input | 1 | Vector table write enable |
| vec_idx_i | input | 4 | Vector table entry to write |
| vec_data_i | input | 32 | Handler address to store |
| mask_we_i | input | 1 | Mask register write enable |
| mask_data_i | input | 16 | New mask value |
| cli_i | input | 1 | Global-disable command |
| sti_i | input | 1 | Global-enable command |
| sti_mask_i | input | 16 | Mask loaded by the global-enable command |
| ret_i | input | 1 | Return-from-handler strobe |
| irq_valid_o | output | 1 | One-cycle dispatch pulse |
| irq_level_o | output | 4 | Level of the latest dispatch |
| irq_vector_o | output | 32 | Handler address of the latest dispatch |
| pending_o | output | 16 | Pending latch |
| active_o | output | 16 | Levels currently in service |
| mask_o | output | 16 | Current mask |
| saved_mask_o | output | 16 | Mask captured by the last global-disable |

## Verification
The bench raises a timer request and a software level 7 while interrupts are globally disabled. A controller that let disable block latching would lose both. One that ignored the disable would dispatch them early. The scoreboard flags either fault as a missing or an unexpected dispatch. After re-enable, the expected order is 6, then 7, then 15, each taken only after the previous return. This catches designs that invert priority, dispatch several levels at once, or let a lower level interrupt a higher one. Further cases are:
- a nested preemption followed by two returns, which exposes a return that clears the wrong active bit;
- a masked level that must be held and later taken;
- a fixed level dispatched during disable;
- a return with nothing active;
- simultaneous commands, which expose a wrong precedence order.

// File: rtl/evc_pkg.sv
package evc_pkg;

    localparam int unsigned EVC_LEVELS = 16;
    localparam int unsigned EVC_ADDR_W = 32;
    localparam int unsigned EVC_FIXED  = 5;

    // Named level assignments (fixed events first, then general purpose)
    typedef enum logic [3:0] {
        LV_EMU   = 4'd0,
        LV_RST   = 4'd1,
        LV_NMI   = 4'd2,
        LV_EXC   = 4'd3,
        LV_RSVD  = 4'd4,
        LV_HWERR = 4'd5,
        LV_TMR   = 4'd6,
        LV_GP0   = 4'd7,
        LV_GP8   = 4'd15
    } evc_level_e;

endpackage

// File: rtl/evc_prio_enc.sv
module evc_prio_enc #(
    parameter int unsigned WIDTH = 16,
    localparam int unsigned IDX_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] req_i,
    output logic             found_o,
    output logic [IDX_W-1:0] idx_o
);

    // Lowest set bit wins: scan downward so the last hit is the smallest index
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/evc_vec_table.sv
module evc_vec_table #(
    parameter int unsigned LEVELS = 16,
    parameter int unsigned ADDR_W = 32,
    localparam int unsigned LVL_W = $clog2(LEVELS)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [LVL_W-1:0]  wr_idx_i,
    input  logic [ADDR_W-1:0] wr_data_i,
    input  logic [LVL_W-1:0]  rd_idx_i,
    output logic [ADDR_W-1:0] rd_data_o
);

    logic [ADDR_W-1:0] tbl_d [LEVELS];
    logic [ADDR_W-1:0] tbl_q [LEVELS];

    always_comb begin
        tbl_d = tbl_q;
        if (wr_en_i) begin
            tbl_d[wr_idx_i] = wr_data_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            for (int i = 0; i < LEVELS; i++) begin
                tbl_q[i] <= '0;
            end
        end else begin
            tbl_q <= tbl_d;
        end
    end

    assign rd_data_o = tbl_q[rd_idx_i];

    AST_VEC_STORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_i |=> tbl_q[$past(wr_idx_i)] == $past(wr_data_i)); // R2

endmodule

// File: rtl/evc_mask_ctl.sv
module evc_mask_ctl #(
    parameter int unsigned LEVELS = 16,
    parameter int unsigned FIXED  = 5
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cli_i,
    input  logic              sti_i,
    input  logic [LEVELS-1:0] sti_mask_i,
    input  logic              mask_we_i,
    input  logic [LEVELS-1:0] mask_data_i,
    output logic [LEVELS-1:0] mask_o,
    output logic [LEVELS-1:0] saved_o
);

    localparam logic [LEVELS-1:0] FIXED_ONES = LEVELS'((64'd1 << FIXED) - 64'd1);

    typedef struct packed {
        logic [LEVELS-1:0] mask;
        logic [LEVELS-1:0] saved;
    } mstate_t;

    mstate_t st_d, st_q;

    // Precedence: disable, then enable, then a plain write
    always_comb begin
        st_d = st_q;
        if (cli_i) begin
            st_d.saved = st_q.mask;
            st_d.mask  = FIXED_ONES;
        end else if (sti_i) begin
            st_d.mask = sti_mask_i | FIXED_ONES;
        end else if (mask_we_i) begin
            st_d.mask = mask_data_i | FIXED_ONES;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.mask  <= FIXED_ONES;
            st_q.saved <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask_o  = st_q.mask;
    assign saved_o = st_q.saved;

    AST_CLI_GATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cli_i |=> mask_o == FIXED_ONES); // R8

    AST_CLI_SAVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cli_i |=> saved_o == $past(mask_o)); // R8

    AST_STI_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sti_i && !cli_i) |=> mask_o == ($past(sti_mask_i) | FIXED_ONES)); // R9

endmodule

// File: rtl/event_ctrl.sv
module event_ctrl
    import evc_pkg::*;
#(
    parameter int unsigned LEVELS = EVC_LEVELS,
    parameter int unsigned ADDR_W = EVC_ADDR_W,
    parameter int unsigned FIXED  = EVC_FIXED,
    localparam int unsigned LVL_W = $clog2(LEVELS)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [LEVELS-1:0] hw_req_i,
    input  logic              raise_i,
    input  logic [LVL_W-1:0]  raise_lvl_i,
    input  logic              vec_we_i,
    input  logic [LVL_W-1:0]  vec_idx_i,
    input  logic [ADDR_W-1:0] vec_data_i,
    input  logic              mask_we_i,
    input  logic [LEVELS-1:0] mask_data_i,
    input  logic              cli_i,
    input  logic              sti_i,
    input  logic [LEVELS-1:0] sti_mask_i,
    input  logic              ret_i,
    output logic              irq_valid_o,
    output logic [LVL_W-1:0]  irq_level_o,
    output logic [ADDR_W-1:0] irq_vector_o,
    output logic [LEVELS-1:0] pending_o,
    output logic [LEVELS-1:0] active_o,
    output logic [LEVELS-1:0] mask_o,
    output logic [LEVELS-1:0] saved_mask_o
);

    typedef struct packed {
        logic [LEVELS-1:0] pend;
        logic [LEVELS-1:0] act;
        logic              valid;
        logic [LVL_W-1:0]  lvl;
        logic [ADDR_W-1:0] vec;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [LEVELS-1:0] mask_w;
    logic [LEVELS-1:0] cand_w;
    logic              cand_found;
    logic [LVL_W-1:0]  cand_idx;
    logic              act_found;
    logic [LVL_W-1:0]  act_idx;
    logic [ADDR_W-1:0] cand_vec;
    logic              disp_fire;
    logic [LEVELS-1:0] set_req;
    logic [LEVELS-1:0] disp_set;
    logic [LEVELS-1:0] ret_clr;

    evc_mask_ctl #(
        .LEVELS (LEVELS),
        .FIXED  (FIXED)
    ) u_mask (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .cli_i       (cli_i),
        .sti_i       (sti_i),
        .sti_mask_i  (sti_mask_i),
        .mask_we_i   (mask_we_i),
        .mask_data_i (mask_data_i),
        .mask_o      (mask_w),
        .saved_o     (saved_mask_o)
    );

    evc_vec_table #(
        .LEVELS (LEVELS),
        .ADDR_W (ADDR_W)
    ) u_table (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (vec_we_i),
        .wr_idx_i  (vec_idx_i),
        .wr_data_i (vec_data_i),
        .rd_idx_i  (cand_idx),
        .rd_data_o (cand_vec)
    );

    assign cand_w = ctl_q.pend & mask_w;

    evc_prio_enc #(.WIDTH(LEVELS)) u_cand_enc (
        .req_i   (cand_w),
        .found_o (cand_found),
        .idx_o   (cand_idx)
    );

    evc_prio_enc #(.WIDTH(LEVELS)) u_act_enc (
        .req_i   (ctl_q.act),
        .found_o (act_found),
        .idx_o   (act_idx)
    );

    always_comb begin
        ctl_d     = ctl_q;
        set_req   = hw_req_i;
        if (raise_i) begin
            set_req = set_req | (LEVELS'(1) << raise_lvl_i);
        end
        // Take the candidate only when it strictly outranks the service level
        disp_fire = cand_found && (!act_found || (cand_idx < act_idx));
        disp_set  = disp_fire ? (LEVELS'(1) << cand_idx) : '0;
        ret_clr   = (ret_i && act_found) ? (LEVELS'(1) << act_idx) : '0;

        ctl_d.pend  = (ctl_q.pend & ~disp_set) | set_req;
        ctl_d.act   = (ctl_q.act & ~ret_clr) | disp_set;
        ctl_d.valid = disp_fire;
        if (disp_fire) begin
            ctl_d.lvl = cand_idx;
            ctl_d.vec = cand_vec;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign irq_valid_o  = ctl_q.valid;
    assign irq_level_o  = ctl_q.lvl;
    assign irq_vector_o = ctl_q.vec;
    assign pending_o    = ctl_q.pend;
    assign active_o     = ctl_q.act;
    assign mask_o       = mask_w;

    AST_NEST_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_valid_o |-> active_o[irq_level_o]
            && ((active_o & ((LEVELS'(1) << irq_level_o) - LEVELS'(1))) == '0)); // R5

    AST_RET_POPS_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ret_i && (active_o != '0) && !disp_fire)
            |=> $countones(active_o) == $countones($past(active_o)) - 1); // R7

    AST_RET_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ret_i && (active_o == '0) && !disp_fire) |=> active_o == '0); // R7

    for (genvar g = 0; g < LEVELS; g++) begin : g_lvl_chk
        AST_PEND_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
            pending_o[g] |=> pending_o[g]
                || (irq_valid_o && irq_level_o == LVL_W'(g))); // R3

        AST_MASK_OBEYED: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (irq_valid_o && irq_level_o == LVL_W'(g))
                |-> $past(mask_w[g] && pending_o[g])); // R4
    end

endmodule

// File: tb/event_ctrl_tb.sv
module event_ctrl_tb;
    import evc_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] hw_req = '0;
    logic        raise = 1'b0;
    logic [3:0]  raise_lvl = '0;
    logic        vec_we = 1'b0;
    logic [3:0]  vec_idx = '0;
    logic [31:0] vec_data = '0;
    logic        mask_we = 1'b0;
    logic [15:0] mask_data = '0;
    logic        cli = 1'b0;
    logic        sti = 1'b0;
    logic [15:0] sti_mask = '0;
    logic        ret = 1'b0;
    logic        irq_valid;
    logic [3:0]  irq_level;
    logic [31:0] irq_vector;
    logic [15:0] pending, active, mask, saved;

    int n_checks = 0;
    int n_err    = 0;
    bit done     = 1'b0;
    int exp_q[$];

    always #5 clk = ~clk;

    event_ctrl u_dut (
        .clk_i (clk), .rst_ni (rst_n),
        .hw_req_i (hw_req), .raise_i (raise), .raise_lvl_i (raise_lvl),
        .vec_we_i (vec_we), .vec_idx_i (vec_idx), .vec_data_i (vec_data),
        .mask_we_i (mask_we), .mask_data_i (mask_data),
        .cli_i (cli), .sti_i (sti), .sti_mask_i (sti_mask), .ret_i (ret),
        .irq_valid_o (irq_valid), .irq_level_o (irq_level),
        .irq_vector_o (irq_vector), .pending_o (pending), .active_o (active),
        .mask_o (mask), .saved_mask_o (saved)
    );

    function automatic logic [31:0] vec_of(input int lvl);
        return 32'hC000_0100 + 32'(lvl) * 32'd8;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_raise(input int lvl);
        @(negedge clk); raise = 1'b1; raise_lvl = 4'(lvl);
        @(negedge clk); raise = 1'b0;
    endtask

    task automatic do_ret();
        @(negedge clk); ret = 1'b1;
        @(negedge clk); ret = 1'b0;
    endtask

    task automatic do_mask(input logic [15:0] m);
        @(negedge clk); mask_we = 1'b1; mask_data = m;
        @(negedge clk); mask_we = 1'b0;
    endtask

    task automatic do_cli();
        @(negedge clk); cli = 1'b1;
        @(negedge clk); cli = 1'b0;
    endtask

    task automatic do_sti(input logic [15:0] m);
        @(negedge clk); sti = 1'b1; sti_mask = m;
        @(negedge clk); sti = 1'b0;
    endtask

    task automatic expect_irq(input int lvl);
        exp_q.push_back(lvl);
    endtask

    // Scoreboard monitor: every dispatch must match the next expected level
    always @(negedge clk) begin
        if (rst_n && irq_valid) begin
            n_checks++;
            if (exp_q.size() == 0) begin
                n_err++;
                $display("FAIL R6 unexpected dispatch actual=%0d expected=none", irq_level);
            end else begin
                int e;
                e = exp_q.pop_front();
                if (irq_level !== 4'(e) || irq_vector !== vec_of(e)) begin
                    n_err++;
                    $display("FAIL R2 R5 R6 dispatch actual=%0d/%h expected=%0d/%h",
                             irq_level, irq_vector, e, vec_of(e));
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(200_000 * 10);
        n_checks++;
        n_err++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        chk("R1 pending", 32'(pending), 32'h0);
        chk("R1 active", 32'(active), 32'h0);
        chk("R1 mask", 32'(mask), 32'h001F);
        chk("R1 saved", 32'(saved), 32'h0);
        chk("R1 valid", 32'(irq_valid), 32'h0);

        // R2 program every vector entry
        for (int i = 0; i < 16; i++) begin
            @(negedge clk); vec_we = 1'b1; vec_idx = 4'(i); vec_data = vec_of(i);
        end
        @(negedge clk); vec_we = 1'b0;

        // R4 fixed bits cannot be cleared
        do_mask(16'h0000);
        chk("R4 fixed bits", 32'(mask), 32'h001F);
        do_mask(16'hFFFF);
        chk("R4 all enabled", 32'(mask), 32'hFFFF);

        // R8 disable, then latch timer and software level 7 without dispatch
        do_cli();
        chk("R8 saved mask", 32'(saved), 32'hFFFF);
        chk("R8 mask gated", 32'(mask), 32'h001F);
        @(negedge clk); hw_req[LV_TMR] = 1'b1;
        @(negedge clk); hw_req = '0;
        do_raise(7);
        tick(5);
        chk("R3 latched while disabled", 32'(pending), 32'h00C0);
        chk("R8 nothing active", 32'(active), 32'h0);

        // R9 re-enable: 6 first, then 7 and a raised 15 in order
        expect_irq(6);
        do_sti(16'hFFFF);
        tick(4);
        chk("R9 mask restored", 32'(mask), 32'hFFFF);
        chk("R5 level 6 active", 32'(active), 32'h0040);
        chk("R5 level 7 waits", 32'(pending), 32'h0080);
        do_raise(15);
        tick(3);
        chk("R3 level 15 pending", 32'(pending), 32'h8080);
        expect_irq(7);
        do_ret();
        tick(4);
        chk("R9 level 7 active", 32'(active), 32'h0080);
        expect_irq(15);
        do_ret();
        tick(4);
        chk("R9 level 15 active", 32'(active), 32'h8000);
        do_ret();
        tick(3);
        chk("R7 all returned", 32'(active), 32'h0);
        chk("R6 pending drained", 32'(pending), 32'h0);

        // R5 nesting: 8 preempts 10
        expect_irq(10);
        do_raise(10);
        tick(4);
        expect_irq(8);
        do_raise(8);
        tick(4);
        chk("R5 nested active", 32'(active), 32'h0500);
        do_ret();
        tick(3);
        chk("R7 inner cleared first", 32'(active), 32'h0400);
        do_ret();
        tick(3);
        chk("R7 outer cleared", 32'(active), 32'h0);

        // R4 masked level held, then taken when unmasked
        do_mask(16'hFDFF);
        do_raise(9);
        tick(5);
        chk("R4 masked held", 32'(pending), 32'h0200);
        expect_irq(9);
        do_mask(16'hFFFF);
        tick(4);
        chk("R4 unmasked taken", 32'(active), 32'h0200);
        do_ret();
        tick(3);

        // R8 fixed level still taken while disabled
        do_cli();
        do_raise(7);
        expect_irq(2);
        do_raise(2);
        tick(4);
        chk("R8 fixed level active", 32'(active), 32'h0004);
        do_ret();
        tick(4);
        chk("R8 level 7 still pending", 32'(pending), 32'h0080);
        expect_irq(7);
        do_sti(16'hFFFF);
        tick(4);
        do_ret();
        tick(3);

        // R5 simultaneous hardware requests: 11 before 12
        expect_irq(11);
        expect_irq(12);
        @(negedge clk); hw_req = 16'h1800;
        @(negedge clk); hw_req = '0;
        tick(4);
        chk("R5 higher of pair active", 32'(active), 32'h0800);
        do_ret();
        tick(4);
        chk("R6 second of pair active", 32'(active), 32'h1000);
        do_ret();
        tick(3);

        // R7 return with nothing active
        do_ret();
        tick(3);
        chk("R7 idle return", 32'(active), 32'h0);

        // R10 command precedence
        @(negedge clk); cli = 1'b1; mask_we = 1'b1; mask_data = 16'hFFFF;
        @(negedge clk); cli = 1'b0; mask_we = 1'b0;
        chk("R10 disable beats write", 32'(mask), 32'h001F);
        @(negedge clk); sti = 1'b1; sti_mask = 16'h00FF; mask_we = 1'b1; mask_data = 16'hFFFF;
        @(negedge clk); sti = 1'b0; mask_we = 1'b0;
        chk("R10 enable beats write", 32'(mask), 32'h00FF);
        do_mask(16'hFFFF);
        tick(3);

        n_checks++;
        if (exp_q.size() != 0) begin
            n_err++;
            $display("FAIL R6 missing dispatches actual=%0d expected=0", exp_q.size());
        end
        finish_run();
    end

endmodule